// File: doc/BRIEF.md
# Serial Channel Interrupt Controller

This block turns the activity of one serial channel into a single interrupt request line. It watches the fill level of the receive FIFO, the level-sensitive receive error flags, the fill level of the transmit FIFO, a write strobe for transmit characters and six external status inputs. From these it derives four interrupt sources: receive special condition, receive character available, transmit, and external/status change. Each source has an enable bit, a pending bit and an under-service bit. A master enable gates all of them.

A host reaches the block through a small register port. It writes the configuration and the external-input enables, issues commands (reset highest under-service, reset transmit pending, reset external status) and reads pending, under-service, receive-error and vector state. An acknowledge strobe accepts the current request. It marks the winning source as under service and latches a vector that names that source. Sources follow a fixed priority: receive special, then receive character, then transmit, then external. A request of higher priority may nest above a source that is already in service.

Register map (3-bit address, 8-bit data). Address 0 is the configuration: bit0 master enable, bit1 receive threshold four, bit2 transmit slot mode, bit3 parity-as-special, bit4 receive-character enable, bit5 receive-special enable, bit6 transmit enable, bit7 external enable. Address 1 holds the external-input enables in bits 5:0. Address 2 is written as commands (bit0 reset highest under-service, bit1 reset transmit pending, bit2 reset external pending) and reads as {under-service[3:0], pending[3:0]}. Address 3 reads the live receive flags {0000, parity, end-of-frame, CRC/framing, overrun}. Address 4 reads the vector {00000, valid, source[1:0]}. Source indices are 0 receive special, 1 receive character, 2 transmit and 3 external.

Top module: `sci_irq_ctrl`

## Requirements
- R1: With configuration bit1 at 0 and bit4 at 1, pending bit 1 is set one edge after rx_count is 1 or more, and it is clear when rx_count is 0.
- R2: With configuration bit1 at 1, pending bit 1 is set only while rx_count is 4 or more.
- R3: Pending bit 0 (with configuration bit5 set) follows the OR of overrun (rx_flags[0]), CRC/framing (rx_flags[1]) and end of frame (rx_flags[2]), plus parity (rx_flags[3]) only when configuration bit3 is 1. Address 3 reads rx_flags.
- R4: With configuration bit2 at 0, transmit pending (bit 2) is set on the edge where tx_count becomes 0 after being non-zero.
- R5: With configuration bit2 at 1, transmit pending is set on the edge where tx_count drops below the FIFO depth (4) after being at the depth.
- R6: Transmit pending is never set before the first tx_wr pulse after reset. It is cleared by tx_wr or by command bit1 at address 2.
- R7: A change on any ext_stat input whose enable bit at address 1 is 1 sets pending bit 3. A change on a disabled input does not. Pending bit 3 stays set until command bit2.
- R8: A pending bit is set only while its source enable bit in the configuration is 1.
- R9: irq_o is 1 exactly when the master enable is 1, some source is pending, and no source of equal or higher priority than the highest pending one is under service.
- R10: irq_ack while irq_o is 1 sets the under-service bit of the highest-priority pending source and latches the vector {1, index}. irq_ack while irq_o is 0 changes nothing.
- R11: Command bit0 at address 2 clears the highest-priority set under-service bit, and only that bit.
- R12: After reset, irq_o is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| rx_count | input | 4 | Receive FIFO occupancy |
| rx_flags | input | 4 | Receive error flags {parity, eof, crc, overrun} |
| tx_count | input | 3 | Transmit FIFO occupancy |
| tx_wr | input | 1 | A transmit character is written this cycle |
| ext_stat | input | 6 | External status inputs |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Every pending bit is a register, so a change on a source input shows in the status register and on irq_o after exactly one rising edge. A configuration write takes effect at its own edge, so it reaches the pending bits one edge later. Acknowledge and commands change under-service and vector state at the edge that samples them, and irq_o follows at once because it is combinational from that state. The bench drives inputs on the falling edge, steps the number of edges each result needs, and samples just after the next falling edge. It sweeps every FIFO count and flag combination against expected values computed in the bench.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;

    localparam int N_SRC = 4;
    localparam int DW    = 8;

    typedef enum logic [1:0] {
        SRC_RXSP = 2'd0,
        SRC_RXCH = 2'd1,
        SRC_TX   = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        REG_CFG   = 3'd0,
        REG_EXTEN = 3'd1,
        REG_STCMD = 3'd2,
        REG_RXST  = 3'd3,
        REG_VEC   = 3'd4
    } reg_e;

    // Configuration byte, bit7 down to bit0
    typedef struct packed {
        logic ext_ie;
        logic tx_ie;
        logic rxsp_ie;
        logic rxch_ie;
        logic par_sp;
        logic tx_slot;
        logic rx_four;
        logic mie;
    } cfg_t;

    // Command bits, bit2 down to bit0
    typedef struct packed {
        logic rst_ext;
        logic rst_txp;
        logic rst_ius;
    } cmd_t;

    // Lowest set index = highest priority
    function automatic logic [1:0] first_set(input logic [N_SRC-1:0] v);
        logic [1:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = 2'(i);
        end
        return r;
    endfunction

    // Bits 0..idx set: sources of equal or higher priority
    function automatic logic [N_SRC-1:0] upto_mask(input logic [1:0] idx);
        logic [N_SRC-1:0] m;
        for (int i = 0; i < N_SRC; i++) begin
            m[i] = (i <= int'(idx));
        end
        return m;
    endfunction

endpackage

// File: rtl/sci_rx_src.sv
module sci_rx_src #(
    parameter int CNT_W     = 4,
    parameter int HI_THRESH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_four,
    input  logic             par_sp,
    input  logic             rxch_ie,
    input  logic             rxsp_ie,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [3:0]       rx_flags,
    output logic             ip_rxch,
    output logic             ip_rxsp
);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI_THRESH);
    localparam logic [CNT_W-1:0] LO_V = CNT_W'(1);

    logic [CNT_W-1:0] thresh;
    logic             cond_ch;
    logic             cond_sp;

    always_comb begin
        thresh  = rx_four ? HI_V : LO_V;
        cond_ch = (rx_count >= thresh);
        cond_sp = (|rx_flags[2:0]) | (rx_flags[3] & par_sp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_rxch <= 1'b0;
            ip_rxsp <= 1'b0;
        end else begin
            ip_rxch <= rxch_ie & cond_ch;
            ip_rxsp <= rxsp_ie & cond_sp;
        end
    end

    assert_rxch_empty_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> !ip_rxch);

    assert_rxsp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_flags == 4'b0) |=> !ip_rxsp);

endmodule

// File: rtl/sci_tx_src.sv
module sci_tx_src #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_slot,
    input  logic             tx_ie,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_wr,
    input  logic             clr_cmd,
    output logic             ip
);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    logic armed_q;
    logic cond_q;
    logic cond;

    always_comb begin
        cond = tx_slot ? (tx_count < DEPTH_V) : (tx_count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cond_q  <= 1'b1;
            ip      <= 1'b0;
        end else begin
            armed_q <= armed_q | tx_wr;
            cond_q  <= cond;
            if (tx_wr || clr_cmd)
                ip <= 1'b0;
            else if (cond && !cond_q && armed_q && tx_ie)
                ip <= 1'b1;
        end
    end

    assert_tx_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> !ip);

    assert_tx_wr_clears_R6: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !ip);

endmodule

// File: rtl/sci_ext_src.sv
module sci_ext_src #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ie,
    input  logic [N-1:0] en,
    input  logic [N-1:0] stat,
    input  logic         clr_cmd,
    output logic         ip
);
    logic [N-1:0] stat_q;
    logic         hit;

    always_comb begin
        hit = |((stat ^ stat_q) & en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ip     <= 1'b0;
        end else begin
            stat_q <= stat;
            ip     <= (ip & ~clr_cmd) | (ie & hit);
        end
    end

    assert_ext_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (ie && |((stat ^ stat_q) & en)) |=> ip);

endmodule

// File: rtl/sci_irq_prio.sv
module sci_irq_prio
    import sci_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mie,
    input  logic [N_SRC-1:0] act,
    input  logic             ack,
    input  logic             rst_ius,
    output logic             irq,
    output logic [N_SRC-1:0] ius,
    output logic [2:0]       vec
);
    logic [1:0]       win;
    logic [1:0]       top_ius;
    logic             blocked;
    logic [N_SRC-1:0] set_m;
    logic [N_SRC-1:0] clr_m;
    logic             take;

    always_comb begin
        win     = first_set(act);
        top_ius = first_set(ius);
        blocked = |(ius & upto_mask(win));
        irq     = mie & (|act) & ~blocked;
        take    = ack & irq;
        set_m   = take ? (N_SRC'(1) << win) : '0;
        clr_m   = (rst_ius && |ius) ? (N_SRC'(1) << top_ius) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ius <= '0;
            vec <= '0;
        end else begin
            ius <= (ius & ~clr_m) | set_m;
            if (take) vec <= {1'b1, win};
        end
    end

    assert_ack_vector_R10: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> (vec[2] && |ius));

    assert_rst_ius_R11: assert property (@(posedge clk) disable iff (rst)
        (rst_ius && |ius && !(ack && irq)) |=>
        ($countones(ius) == $past($countones(ius)) - 1));

endmodule

// File: rtl/sci_irq_ctrl.sv
module sci_irq_ctrl
    import sci_irq_pkg::*;
#(
    parameter int RX_CNT_W  = 4,
    parameter int RX_HI     = 4,
    parameter int TX_DEPTH  = 4,
    parameter int N_EXT     = 6,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [2:0]          host_addr,
    input  logic [DW-1:0]       host_wdata,
    output logic [DW-1:0]       host_rdata,
    input  logic [RX_CNT_W-1:0] rx_count,
    input  logic [3:0]          rx_flags,
    input  logic [TX_CNT_W-1:0] tx_count,
    input  logic                tx_wr,
    input  logic [N_EXT-1:0]    ext_stat,
    input  logic                irq_ack,
    output logic                irq_o
);
    cfg_t             cfg_q;
    logic [N_EXT-1:0] ext_en_q;
    cmd_t             cmd;
    logic [N_SRC-1:0] ip;
    logic [N_SRC-1:0] ie;
    logic [N_SRC-1:0] ius;
    logic [2:0]       vec;

    always_comb begin
        cmd = (host_we && host_addr == REG_STCMD) ? cmd_t'(host_wdata[2:0]) : '0;
        ie  = {cfg_q.ext_ie, cfg_q.tx_ie, cfg_q.rxch_ie, cfg_q.rxsp_ie};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            ext_en_q <= '0;
        end else if (host_we) begin
            if (host_addr == REG_CFG)   cfg_q    <= cfg_t'(host_wdata);
            if (host_addr == REG_EXTEN) ext_en_q <= host_wdata[N_EXT-1:0];
        end
    end

    sci_rx_src #(.CNT_W(RX_CNT_W), .HI_THRESH(RX_HI)) u_rx (
        .clk(clk), .rst(rst),
        .rx_four(cfg_q.rx_four), .par_sp(cfg_q.par_sp),
        .rxch_ie(cfg_q.rxch_ie), .rxsp_ie(cfg_q.rxsp_ie),
        .rx_count(rx_count), .rx_flags(rx_flags),
        .ip_rxch(ip[SRC_RXCH]), .ip_rxsp(ip[SRC_RXSP])
    );

    sci_tx_src #(.DEPTH(TX_DEPTH), .CNT_W(TX_CNT_W)) u_tx (
        .clk(clk), .rst(rst),
        .tx_slot(cfg_q.tx_slot), .tx_ie(cfg_q.tx_ie),
        .tx_count(tx_count), .tx_wr(tx_wr), .clr_cmd(cmd.rst_txp),
        .ip(ip[SRC_TX])
    );

    sci_ext_src #(.N(N_EXT)) u_ext (
        .clk(clk), .rst(rst),
        .ie(cfg_q.ext_ie), .en(ext_en_q), .stat(ext_stat),
        .clr_cmd(cmd.rst_ext), .ip(ip[SRC_EXT])
    );

    sci_irq_prio u_prio (
        .clk(clk), .rst(rst),
        .mie(cfg_q.mie), .act(ip & ie),
        .ack(irq_ack), .rst_ius(cmd.rst_ius),
        .irq(irq_o), .ius(ius), .vec(vec)
    );

    always_comb begin
        case (host_addr)
            REG_CFG:   host_rdata = cfg_q;
            REG_EXTEN: host_rdata = DW'(ext_en_q);
            REG_STCMD: host_rdata = {ius, ip};
            REG_RXST:  host_rdata = {4'b0, rx_flags};
            REG_VEC:   host_rdata = {5'b0, vec};
            default:   host_rdata = '0;
        endcase
    end

    assert_pending_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.rxch_ie && !host_we) |=> !ip[SRC_RXCH]);

endmodule

// File: tb/sci_irq_ctrl_bench.sv
module sci_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [3:0] rx_count = '0;
    logic [3:0] rx_flags = '0;
    logic [2:0] tx_count = '0;
    logic       tx_wr = 1'b0;
    logic [5:0] ext_stat = '0;
    logic       irq_ack = 1'b0;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sci_irq_ctrl u_sci_irq_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_count(rx_count), .rx_flags(rx_flags), .tx_count(tx_count),
        .tx_wr(tx_wr), .ext_stat(ext_stat), .irq_ack(irq_ack), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        tick(1);
        host_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output int d);
        host_addr = a;
        #1;
        d = int'(host_rdata);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d;
        int seq[7] = '{3, 4, 3, 0, 4, 2, 0};
        tick(3);
        rst = 1'b0;
        tick(1);

        // R12: reset state
        check("R12 irq", int'(irq_o), 0);
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), d);
            check("R12 reg", d, 0);
        end

        // R1 / R2: receive threshold sweep
        for (int four = 0; four < 2; four++) begin
            wreg(3'd0, 8'h11 | 8'(four << 1));
            for (int c = 0; c < 16; c++) begin
                rx_count = 4'(c);
                tick(1);
                rreg(3'd2, d);
                if (four == 0) begin
                    check("R1 rxch pending", (d >> 1) & 1, int'(c >= 1));
                    check("R1 irq", int'(irq_o), int'(c >= 1));
                end else begin
                    check("R2 rxch pending", (d >> 1) & 1, int'(c >= 4));
                    check("R2 irq", int'(irq_o), int'(c >= 4));
                end
            end
        end
        rx_count = '0;

        // R3: special condition sweep
        for (int p = 0; p < 2; p++) begin
            wreg(3'd0, 8'h21 | 8'(p << 3));
            for (int f = 0; f < 16; f++) begin
                rx_flags = 4'(f);
                tick(1);
                rreg(3'd2, d);
                check("R3 rxsp pending", d & 1,
                      int'(((f & 7) != 0) || (((f >> 3) & p) != 0)));
                rreg(3'd3, d);
                check("R3 rx status", d, f);
            end
        end
        rx_flags = '0;

        // R8: disabled receive source stays idle
        wreg(3'd0, 8'h01);
        rx_count = 4'd5;
        tick(1);
        rreg(3'd2, d);
        check("R8 pending gated", d, 0);
        check("R8 irq", int'(irq_o), 0);
        rx_count = '0;

        // R6: no transmit pending before first write
        wreg(3'd0, 8'h41);
        tx_count = 3'd1; tick(1);
        tx_count = 3'd0; tick(1);
        rreg(3'd2, d);
        check("R6 unarmed", (d >> 2) & 1, 0);
        tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
        tx_count = 3'd1; tick(1);
        rreg(3'd2, d);
        check("R4 not empty", (d >> 2) & 1, 0);
        tx_count = 3'd0; tick(1);
        rreg(3'd2, d);
        check("R4 empty edge", (d >> 2) & 1, 1);
        check("R4 irq", int'(irq_o), 1);
        tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
        rreg(3'd2, d);
        check("R6 write clears", (d >> 2) & 1, 0);

        // R4 / R5: transmit mode sweeps
        for (int m = 0; m < 2; m++) begin
            bit prev;
            bit exp_ip;
            tx_count = 3'd4; tick(2);
            wreg(3'd2, 8'h02);
            wreg(3'd0, 8'h41 | 8'(m << 2));
            tick(1);
            rreg(3'd2, d);
            check("R6 cmd clears", (d >> 2) & 1, 0);
            prev = 1'b0; exp_ip = 1'b0;
            for (int k = 0; k < 7; k++) begin
                bit cnd;
                tx_count = 3'(seq[k]);
                tick(1);
                cnd = (m == 1) ? (seq[k] < 4) : (seq[k] == 0);
                if (cnd && !prev) exp_ip = 1'b1;
                prev = cnd;
                rreg(3'd2, d);
                if (m == 0) check("R4 sweep", (d >> 2) & 1, int'(exp_ip));
                else        check("R5 sweep", (d >> 2) & 1, int'(exp_ip));
            end
        end
        tx_count = 3'd4; tick(1);
        wreg(3'd2, 8'h02);
        tick(1);

        // R7: external status per-input enable sweep
        wreg(3'd0, 8'h81);
        for (int i = 0; i < 6; i++) begin
            wreg(3'd1, 8'(1 << i));
            tick(1);
            for (int j = 0; j < 6; j++) begin
                ext_stat = ext_stat ^ (6'd1 << j);
                tick(1);
                rreg(3'd2, d);
                check("R7 ext pending", (d >> 3) & 1, int'(i <= j));
            end
            wreg(3'd2, 8'h04);
            rreg(3'd2, d);
            check("R7 ext cleared", (d >> 3) & 1, 0);
        end

        // R8: external source disabled
        wreg(3'd0, 8'h01);
        wreg(3'd1, 8'h3f);
        ext_stat = ext_stat ^ 6'd1;
        tick(1);
        rreg(3'd2, d);
        check("R8 ext gated", (d >> 3) & 1, 0);

        // R9 / R10 / R11: priority, acknowledge and nesting
        wreg(3'd0, 8'hB1);
        ext_stat = ext_stat ^ 6'd4;
        rx_flags = 4'd1;
        rx_count = 4'd1;
        tick(1);
        rreg(3'd2, d);
        check("R9 pending set", d, 8'h0B);
        check("R9 irq raised", int'(irq_o), 1);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        rreg(3'd4, d);
        check("R10 vector rxsp", d, 4);
        rreg(3'd2, d);
        check("R10 ius rxsp", d, 8'h1B);
        check("R9 blocked", int'(irq_o), 0);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        rreg(3'd2, d);
        check("R10 ack ignored", d, 8'h1B);
        wreg(3'd2, 8'h01);
        rreg(3'd2, d);
        check("R11 ius cleared", d >> 4, 0);
        check("R9 irq again", int'(irq_o), 1);
        rx_flags = '0;
        tick(1);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        rreg(3'd4, d);
        check("R10 vector rxch", d, 5);
        rreg(3'd2, d);
        check("R10 ius rxch", d, 8'h2A);
        check("R9 rxch blocks", int'(irq_o), 0);
        rx_flags = 4'd2;
        tick(1);
        check("R9 nested irq", int'(irq_o), 1);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        rreg(3'd2, d);
        check("R10 nested ius", d >> 4, 3);
        rreg(3'd4, d);
        check("R10 nested vector", d, 4);
        wreg(3'd2, 8'h01);
        rreg(3'd2, d);
        check("R11 highest only", d >> 4, 2);
        wreg(3'd0, 8'hB0);
        check("R9 master off", int'(irq_o), 0);
        wreg(3'd2, 8'h01);
        rreg(3'd2, d);
        check("R11 last cleared", d >> 4, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule